// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels and turns each channel's expiry pulse into an interrupt. Every channel carries a small configuration: an enable, a level-or-edge choice, a message-delivery enable and a route number that picks one of the interrupt lines. A level channel latches a status bit and holds its line until software writes a 1 to that bit; an edge channel produces a single-cycle pulse and never latches status. A channel in message mode drives no line at all and instead raises a memory-write request whose address and data come from that channel's 64-bit message word.

A legacy replacement mode pins channel 0 to line 0 and channel 1 to line 8 regardless of their route fields. In this mode it also mutes the two external legacy interrupt inputs, a periodic-tick input and a clock-alarm input, that normally pass through to those two lines, and it lowers a gate output that enables the external legacy tick source. Several sources that land on one line are ORed.

Top module: `tmr_irq_router`

## Requirements
- R1: An expiry on an active level channel (channel enable and global enable both 1, message mode 0, level mode 1) sets that channel's status bit one cycle after the pulse is sampled and holds its routed line high until the bit is cleared.
- R2: An expiry on an active edge channel (level mode 0) drives its routed line high for exactly one cycle and leaves its status bit at 0.
- R3: A status write clears each bit written as 1 and leaves bits written as 0 unchanged; an expiry sampled in the same cycle as a clearing write keeps the bit set.
- R4: Clearing a channel's enable or the global enable clears that channel's status bit and line on the next cycle, and expiries on an inactive channel have no effect.
- R5: Outside legacy mode a channel's 5-bit route field selects the line it drives; a route at or above the line count drives nothing; a line driven by several channels is high while any of them requests it.
- R6: In legacy mode channel 0 drives line 0 and channel 1 drives line 8, ignoring their route fields.
- R7: Outside legacy mode the tick input appears on line 0 and the alarm input on line 8 one cycle after sampling; in legacy mode both are muted; the alarm input level is tracked throughout, so on leaving legacy mode line 8 shows its latest level.
- R8: The legacy gate output is 1 after reset, goes to 0 one cycle after legacy mode is entered and back to 1 one cycle after it is left.
- R9: An expiry on an active channel in message mode drives no line and raises the message request two cycles after the pulse is sampled, with the address taken from bits 63:32 and the data from bits 31:0 of the channel's message word.
- R10: A raised message request keeps its address and data steady until accepted by ready; requests from several channels are all delivered, lowest channel index first, and the next one is presented in the cycle after acceptance.
- R11: Turning message mode on for a channel clears its pending level status and drops its line on the next cycle.
- R12: After reset all lines are low, all status bits are 0, no message is requested and the gate output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Legacy replacement routing on |
| ch_fire | input | NUM_CH | One-cycle expiry pulse per channel |
| ch_enable | input | NUM_CH | Per-channel interrupt enable |
| ch_level | input | NUM_CH | 1 = level signalling, 0 = edge |
| ch_msg_en | input | NUM_CH | Per-channel message delivery enable |
| ch_route | input | NUM_CH*5 | Route number per channel, channel i at bits 5i+4:5i |
| ch_msg_word | input | NUM_CH*64 | Message word per channel, address high half, data low half |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_CH | Status write data, 1 clears |
| leg_tick_in | input | 1 | Legacy periodic tick interrupt input |
| leg_alarm_in | input | 1 | Legacy clock alarm interrupt input |
| msg_ready | input | 1 | Downstream accepts the message |
| irq_lines | output | NUM_LINES | Interrupt line bank |
| status_out | output | NUM_CH | Interrupt status bits |
| msg_valid | output | 1 | Message request |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |
| tick_gate_out | output | 1 | Enable for the legacy tick source |

## Verification
A wrong status bit shows up on the routed line and on the status port in the very next cycle, so level holding, write-one clearing and the same-cycle race between expiry and clear are all observed one edge after the stimulus. A corrupted route or legacy override lights a neighbouring line at once, which the checks catch by comparing the whole line vector rather than a single bit. A lost or reordered message shows as a wrong address on the request two cycles after the expiry, or as a request that drops early while ready is low.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int ROUTE_W     = 5;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int WORD_W      = ADDR_W + DATA_W;
    localparam int LEG_LINE_LO = 0;
    localparam int LEG_LINE_HI = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    typedef enum logic [1:0] {
        DLV_NONE  = 2'd0,
        DLV_LEVEL = 2'd1,
        DLV_EDGE  = 2'd2,
        DLV_MSG   = 2'd3
    } dlv_kind_e;

    function automatic dlv_kind_e kind_of(logic act, logic msg, logic lvl);
        if (!act)     return DLV_NONE;
        else if (msg) return DLV_MSG;
        else if (lvl) return DLV_LEVEL;
        else          return DLV_EDGE;
    endfunction
endpackage

// File: rtl/tmr_irq_status.sv
module tmr_irq_status
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_en,
    input  logic [NUM_CH-1:0] ch_fire,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_level,
    input  logic [NUM_CH-1:0] ch_msg_en,
    input  logic              sts_wr,
    input  logic [NUM_CH-1:0] sts_wdata,
    output logic [NUM_CH-1:0] sts_q,
    output logic [NUM_CH-1:0] pulse_q,
    output logic [NUM_CH-1:0] msg_fire,
    output logic [NUM_CH-1:0] active
);
    logic [NUM_CH-1:0] set_lvl, set_edge, clr;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            active[i]   = ch_enable[i] & glb_en;
            set_lvl[i]  = 1'b0;
            set_edge[i] = 1'b0;
            msg_fire[i] = 1'b0;
            if (ch_fire[i]) begin
                unique case (kind_of(active[i], ch_msg_en[i], ch_level[i]))
                    DLV_LEVEL: set_lvl[i]  = 1'b1;
                    DLV_EDGE:  set_edge[i] = 1'b1;
                    DLV_MSG:   msg_fire[i] = 1'b1;
                    default:   ;
                endcase
            end
            clr[i] = (sts_wr & sts_wdata[i]) | ~active[i] | ch_msg_en[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q   <= '0;
            pulse_q <= '0;
        end else begin
            sts_q   <= (sts_q & ~clr) | set_lvl;
            pulse_q <= set_edge;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R4
        inactive_clears_chk: assert property (@(posedge clk) disable iff (rst)
            !active[g] |=> !sts_q[g]);
        // R11
        msg_mode_no_line_chk: assert property (@(posedge clk) disable iff (rst)
            ch_msg_en[g] |=> (!sts_q[g] && !pulse_q[g]));
        // R3
        write_one_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (sts_wr && sts_wdata[g] && !ch_fire[g]) |=> !sts_q[g]);
        // R2
        edge_no_status_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_fire[g] && active[g] && !ch_level[g] && !sts_q[g]) |=> !sts_q[g]);
    end
endmodule

// File: rtl/tmr_irq_msg.sv
module tmr_irq_msg
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        msg_fire,
    input  logic [NUM_CH-1:0]        keep,
    input  logic [NUM_CH*WORD_W-1:0] ch_msg_word,
    input  logic                     msg_ready,
    output logic                     msg_valid,
    output msg_t                     msg_out
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0] pend_q, take;
    logic [IDX_W-1:0]  sel;
    logic              any, load;
    msg_t              pick;

    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
        pick = ch_msg_word[sel*WORD_W +: WORD_W];
        load = !msg_valid || msg_ready;
        take = '0;
        if (load && any) take[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else begin
            pend_q <= (pend_q & ~take & keep) | msg_fire;
            if (load) begin
                msg_valid <= any;
                if (any) msg_out <= pick;
            end
        end
    end

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_out)));
    // R10
    msg_onehot_take_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));
endmodule

// File: rtl/tmr_irq_legacy.sv
module tmr_irq_legacy (
    input  logic clk,
    input  logic rst,
    input  logic legacy_mode,
    input  logic leg_tick_in,
    input  logic leg_alarm_in,
    output logic tick_q,
    output logic alarm_q,
    output logic gate_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= 1'b0;
            alarm_q <= 1'b0;
            gate_q  <= 1'b1;
        end else begin
            tick_q  <= leg_tick_in;
            alarm_q <= leg_alarm_in;
            gate_q  <= !legacy_mode;
        end
    end

    // R8
    gate_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_mode |=> !gate_q);
    // R7
    alarm_tracked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (alarm_q == $past(leg_alarm_in)));
endmodule

// File: rtl/tmr_irq_lines.sv
module tmr_irq_lines
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24
) (
    input  logic [NUM_CH-1:0]         req,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic                      legacy_mode,
    input  logic                      tick_q,
    input  logic                      alarm_q,
    output logic [NUM_LINES-1:0]      irq_lines
);
    logic [ROUTE_W-1:0] eff_route [NUM_CH];

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (legacy_mode && i == 0)      eff_route[i] = ROUTE_W'(LEG_LINE_LO);
            else if (legacy_mode && i == 1) eff_route[i] = ROUTE_W'(LEG_LINE_HI);
            else                            eff_route[i] = ch_route[i*ROUTE_W +: ROUTE_W];
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NUM_CH; i++)
                if (req[i] && eff_route[i] == ROUTE_W'(l)) hit = 1'b1;
            if (l == LEG_LINE_LO && !legacy_mode) hit = hit | tick_q;
            if (l == LEG_LINE_HI && !legacy_mode) hit = hit | alarm_q;
        end
        assign irq_lines[l] = hit;
    end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      glb_en,
    input  logic                      legacy_mode,
    input  logic [NUM_CH-1:0]         ch_fire,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH*5-1:0]       ch_route,
    input  logic [NUM_CH*64-1:0]      ch_msg_word,
    input  logic                      sts_wr,
    input  logic [NUM_CH-1:0]         sts_wdata,
    input  logic                      leg_tick_in,
    input  logic                      leg_alarm_in,
    input  logic                      msg_ready,
    output logic [NUM_LINES-1:0]      irq_lines,
    output logic [NUM_CH-1:0]         status_out,
    output logic                      msg_valid,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data,
    output logic                      tick_gate_out
);
    logic [NUM_CH-1:0] sts_q, pulse_q, msg_fire, active;
    logic              tick_q, alarm_q;
    msg_t              msg_out;

    tmr_irq_status #(.NUM_CH(NUM_CH)) u_status (
        .clk(clk), .rst(rst), .glb_en(glb_en), .ch_fire(ch_fire),
        .ch_enable(ch_enable), .ch_level(ch_level), .ch_msg_en(ch_msg_en),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_q(sts_q),
        .pulse_q(pulse_q), .msg_fire(msg_fire), .active(active)
    );

    tmr_irq_msg #(.NUM_CH(NUM_CH)) u_msg (
        .clk(clk), .rst(rst), .msg_fire(msg_fire), .keep(active & ch_msg_en),
        .ch_msg_word(ch_msg_word), .msg_ready(msg_ready),
        .msg_valid(msg_valid), .msg_out(msg_out)
    );

    tmr_irq_legacy u_legacy (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode),
        .leg_tick_in(leg_tick_in), .leg_alarm_in(leg_alarm_in),
        .tick_q(tick_q), .alarm_q(alarm_q), .gate_q(tick_gate_out)
    );

    tmr_irq_lines #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) u_lines (
        .req(sts_q | pulse_q), .ch_route(ch_route), .legacy_mode(legacy_mode),
        .tick_q(tick_q), .alarm_q(alarm_q), .irq_lines(irq_lines)
    );

    assign status_out = sts_q;
    assign msg_addr   = msg_out.addr;
    assign msg_data   = msg_out.data;

    // R6
    legacy_ch0_line_chk: assert property (@(posedge clk) disable iff (rst)
        (legacy_mode && status_out[0]) |-> irq_lines[LEG_LINE_LO]);
    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!msg_valid && status_out == '0 && tick_gate_out));
endmodule

// File: tb/test_tmr_irq_router.sv
module test_tmr_irq_router;
    localparam int NC = 4;
    localparam int NL = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           glb_en = 1'b0, legacy_mode = 1'b0;
    logic [NC-1:0]  ch_fire = '0, ch_enable = '0, ch_level = '0, ch_msg_en = '0;
    logic [NC*5-1:0]  ch_route = '0;
    logic [NC*64-1:0] ch_msg_word = '0;
    logic           sts_wr = 1'b0;
    logic [NC-1:0]  sts_wdata = '0;
    logic           leg_tick_in = 1'b0, leg_alarm_in = 1'b0, msg_ready = 1'b0;
    logic [NL-1:0]  irq_lines;
    logic [NC-1:0]  status_out;
    logic           msg_valid;
    logic [31:0]    msg_addr, msg_data;
    logic           tick_gate_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_irq_router #(.NUM_CH(NC), .NUM_LINES(NL)) i_tmr_irq_router (
        .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_mode(legacy_mode),
        .ch_fire(ch_fire), .ch_enable(ch_enable), .ch_level(ch_level),
        .ch_msg_en(ch_msg_en), .ch_route(ch_route), .ch_msg_word(ch_msg_word),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .leg_tick_in(leg_tick_in),
        .leg_alarm_in(leg_alarm_in), .msg_ready(msg_ready), .irq_lines(irq_lines),
        .status_out(status_out), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .tick_gate_out(tick_gate_out)
    );

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NL-1:0] ln(int l);
        logic [NL-1:0] v = '0;
        v[l] = 1'b1;
        return v;
    endfunction

    task automatic set_ch(int i, bit en, bit lvl, bit msg, int route);
        ch_enable[i] = en;
        ch_level[i]  = lvl;
        ch_msg_en[i] = msg;
        ch_route[i*5 +: 5] = 5'(route);
    endtask

    task automatic fire(logic [NC-1:0] m);
        ch_fire = m;
        step();
        ch_fire = '0;
    endtask

    task automatic wr_sts(logic [NC-1:0] d);
        sts_wr = 1'b1;
        sts_wdata = d;
        step();
        sts_wr = 1'b0;
        sts_wdata = '0;
    endtask

    task automatic quiesce();
        ch_enable = '0; ch_level = '0; ch_msg_en = '0; ch_route = '0;
        legacy_mode = 1'b0; leg_tick_in = 1'b0; leg_alarm_in = 1'b0;
        msg_ready = 1'b1;
        step(3);
        msg_ready = 1'b0;
        glb_en = 1'b1;
        step();
    endtask

    task automatic t_reset();
        chk("R12 lines", irq_lines, '0);
        chk("R12 status", status_out, '0);
        chk("R12 msg_valid", msg_valid, 0);
        chk("R12 gate", tick_gate_out, 1);
    endtask

    task automatic t_level();
        quiesce();
        set_ch(2, 1, 1, 0, 5);
        fire(4'b0100);
        chk("R1 status set", status_out, 4'b0100);
        chk("R1 line5 high", irq_lines, ln(5));
        step(3);
        chk("R1 line5 held", irq_lines, ln(5));
        wr_sts(4'b1011);
        chk("R3 write zero no effect", status_out, 4'b0100);
        wr_sts(4'b0100);
        chk("R3 write one clears", status_out, 4'b0000);
        chk("R3 line dropped", irq_lines, '0);
    endtask

    task automatic t_edge();
        quiesce();
        set_ch(3, 1, 0, 0, 7);
        fire(4'b1000);
        chk("R2 pulse high", irq_lines, ln(7));
        chk("R2 status stays 0", status_out, 4'b0000);
        step();
        chk("R2 pulse one cycle", irq_lines, '0);
    endtask

    task automatic t_or_route();
        quiesce();
        set_ch(2, 1, 1, 0, 10);
        set_ch(3, 1, 1, 0, 10);
        set_ch(1, 1, 1, 0, 30);
        fire(4'b1110);
        chk("R5 shared line", irq_lines, ln(10));
        wr_sts(4'b0100);
        chk("R5 line held by other", irq_lines, ln(10));
        wr_sts(4'b1010);
        chk("R5 shared line low", irq_lines, '0);
    endtask

    task automatic t_race();
        quiesce();
        set_ch(2, 1, 1, 0, 4);
        fire(4'b0100);
        ch_fire = 4'b0100;
        sts_wr = 1'b1;
        sts_wdata = 4'b0100;
        step();
        ch_fire = '0; sts_wr = 1'b0; sts_wdata = '0;
        chk("R3 expiry beats clear", status_out, 4'b0100);
        wr_sts(4'b0100);
    endtask

    task automatic t_disable();
        quiesce();
        set_ch(2, 1, 1, 0, 6);
        fire(4'b0100);
        ch_enable[2] = 1'b0;
        step();
        chk("R4 disable clears", status_out, 4'b0000);
        chk("R4 disable drops line", irq_lines, '0);
        fire(4'b0100);
        chk("R4 inactive fire ignored", irq_lines, '0);
        ch_enable[2] = 1'b1;
        fire(4'b0100);
        glb_en = 1'b0;
        step();
        chk("R4 global off clears", status_out, 4'b0000);
        chk("R4 global off line", irq_lines, '0);
    endtask

    task automatic t_legacy();
        quiesce();
        leg_tick_in = 1'b1;
        leg_alarm_in = 1'b1;
        step();
        chk("R7 passthrough", irq_lines, ln(0) | ln(8));
        legacy_mode = 1'b1;
        step();
        chk("R7 muted in legacy", irq_lines, '0);
        chk("R8 gate low", tick_gate_out, 0);
        set_ch(0, 1, 1, 0, 12);
        set_ch(1, 1, 0, 0, 3);
        fire(4'b0001);
        chk("R6 ch0 to line0", irq_lines, ln(0));
        wr_sts(4'b0001);
        fire(4'b0010);
        chk("R6 ch1 to line8", irq_lines, ln(8));
        leg_alarm_in = 1'b0;
        leg_tick_in = 1'b0;
        step();
        leg_alarm_in = 1'b1;
        step();
        legacy_mode = 1'b0;
        step();
        chk("R7 alarm tracked", irq_lines, ln(8));
        chk("R8 gate high", tick_gate_out, 1);
    endtask

    task automatic t_msg();
        quiesce();
        set_ch(2, 1, 1, 1, 5);
        set_ch(3, 1, 0, 1, 9);
        ch_msg_word[2*64 +: 64] = 64'hA000_0020_D000_0002;
        ch_msg_word[3*64 +: 64] = 64'hA000_0030_D000_0003;
        fire(4'b1100);
        chk("R9 not yet valid", msg_valid, 0);
        step();
        chk("R9 valid", msg_valid, 1);
        chk("R9 addr", msg_addr, 32'hA000_0020);
        chk("R9 data", msg_data, 32'hD000_0002);
        chk("R9 no line", irq_lines, '0);
        step(3);
        chk("R10 held valid", msg_valid, 1);
        chk("R10 held addr", msg_addr, 32'hA000_0020);
        msg_ready = 1'b1;
        step();
        chk("R10 next valid", msg_valid, 1);
        chk("R10 next addr", msg_addr, 32'hA000_0030);
        chk("R10 next data", msg_data, 32'hD000_0003);
        step();
        chk("R10 drained", msg_valid, 0);
        msg_ready = 1'b0;
    endtask

    task automatic t_msg_clear();
        quiesce();
        set_ch(1, 1, 1, 0, 11);
        fire(4'b0010);
        chk("R11 pending set", status_out, 4'b0010);
        ch_msg_en[1] = 1'b1;
        step();
        chk("R11 msg on clears", status_out, 4'b0000);
        chk("R11 line dropped", irq_lines, '0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        t_reset();
        t_level();
        t_edge();
        t_or_route();
        t_race();
        t_disable();
        t_legacy();
        t_msg();
        t_msg_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule